// File: doc/BRIEF.md
# Avionics Word Holding Latch with Half-Word Readout

This block sits between a serial avionics receiver and a host processor. When the receiver reports that a full 32-bit word has been assembled, by pulsing an end-of-word strobe, the block may capture that word into a holding register. A label filter controls the capture. When the filter is switched off, every word is taken. When it is switched on, a word is taken only if its ninth and tenth serial bits equal two programmed match bits. Each captured word raises a pending flag for the host.

The host reads the held word over a 16-bit bus in two halves, using a read strobe and a half-select input. A small state machine records which halves have been read since the last capture. It drops the pending flag once both halves have been read, in either order. If a newer accepted word arrives before the host has finished, that word replaces the held word and the tracking starts again.

The tracker has four states. `ST_EMPTY` means no unread word. `ST_FRESH` means a word is held and neither half has been read. `ST_LO_DONE` means only the low half has been read. `ST_HI_DONE` means only the high half has been read. The transitions are as follows:
- accept: any state goes to `ST_FRESH` when an accepted word is captured.
- read-low: `ST_FRESH` goes to `ST_LO_DONE`, and `ST_HI_DONE` goes to `ST_EMPTY`.
- read-high: `ST_FRESH` goes to `ST_HI_DONE`, and `ST_LO_DONE` goes to `ST_EMPTY`.
- repeat-read: reading a half that has already been read keeps the current state.
- idle-read: a read in `ST_EMPTY` stays in `ST_EMPTY`.

If accept and a read fall in the same cycle, accept wins.

Top module: `arinc_word_reader`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `data_ready`, `dbus_oe` and `dbus` are all 0.
- R2: An accepted end-of-word pulse copies `rx_word` into the holding register at that clock edge, and `data_ready` reads 1 from the next cycle on.
- R3: With `dec_en`=1, a word is accepted only when `rx_word[8]` (serial bit 9) equals `dec_bits[0]` and `rx_word[9]` (serial bit 10) equals `dec_bits[1]`.
- R4: With `dec_en`=0, every end-of-word pulse is accepted, whatever the label bits are.
- R5: An end-of-word pulse for a rejected word changes neither the held word nor `data_ready`.
- R6: A cycle with `rd_en`=1 puts the held word's bits [15:0] on `dbus` in the next cycle when `half_sel`=0, and bits [31:16] when `half_sel`=1.
- R7: `data_ready` falls only after both halves have been read, in either order. Reading the same half again does not clear it. A read while nothing is pending leaves `data_ready` at 0.
- R8: A newly accepted word overwrites an unread or partly read word and clears both read-tracking bits. When it coincides with a read, that read returns a half of the previous word and the new word counts as unread.
- R9: `dbus_oe` equals `rd_en` delayed by one cycle, and `dbus` keeps its value in every cycle that follows one with `rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eow | input | 1 | End-of-word pulse from the receiver, one cycle wide |
| rx_word | input | 32 | Assembled word; bit 0 is serial bit 1 |
| dec_en | input | 1 | Label filter enable |
| dec_bits | input | 2 | Match values for serial bits 10 and 9 |
| rd_en | input | 1 | Host read strobe, active high |
| half_sel | input | 1 | 0 selects bits [15:0], 1 selects bits [31:16] |
| dbus | output | 16 | Read data to the host |
| dbus_oe | output | 1 | Bus drive enable, follows the read strobe |
| data_ready | output | 1 | An accepted word has not yet been fully read |

## Verification
Capture of a new word and a host read can land on the same clock edge. The bench provokes this by raising `eow` together with `rd_en` just after the previous word has been fully read. It then checks that the bus carries the low half of the old word, that `data_ready` is set, and that the next low-half read returns the new word. The bench also places a rejected word between the two half-reads and checks that the second half still comes from the original word and that the flag clears as usual.

// File: rtl/arinc_rd_pkg.sv
package arinc_rd_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FRESH   = 2'd1,
        ST_LO_DONE = 2'd2,
        ST_HI_DONE = 2'd3
    } rd_state_e;

endpackage

// File: rtl/label_filter.sv
module label_filter #(
    parameter int WORD_W  = 32,
    parameter int LBL_LSB = 8
) (
    input  logic              eow,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              dec_en,
    input  logic [1:0]        dec_bits,
    output logic              accept
);
    logic label_hit;

    always_comb begin
        label_hit = (rx_word[LBL_LSB +: 2] == dec_bits);
        accept    = eow && (!dec_en || label_hit);
    end
endmodule

// File: rtl/word_latch.sv
module word_latch #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/read_tracker.sv
module read_tracker
    import arinc_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic rd_en,
    input  logic half_sel,
    output logic pending
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = ST_FRESH;
        end else if (rd_en) begin
            unique case (state_q)
                ST_EMPTY:   state_d = ST_EMPTY;
                ST_FRESH:   state_d = half_sel ? ST_HI_DONE : ST_LO_DONE;
                ST_LO_DONE: state_d = half_sel ? ST_EMPTY   : ST_LO_DONE;
                ST_HI_DONE: state_d = half_sel ? ST_HI_DONE : ST_EMPTY;
                default:    state_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        pending = (state_q != ST_EMPTY);
    end
endmodule

// File: rtl/half_mux.sv
module half_mux #(
    parameter int WORD_W = 32,
    localparam int BUS_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              half_sel,
    input  logic [WORD_W-1:0] held,
    output logic [BUS_W-1:0]  dbus,
    output logic              dbus_oe
);
    logic [BUS_W-1:0] pick;

    always_comb begin
        pick = half_sel ? held[WORD_W-1:BUS_W] : held[BUS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbus    <= '0;
            dbus_oe <= 1'b0;
        end else begin
            dbus_oe <= rd_en;
            if (rd_en)
                dbus <= pick;
        end
    end
endmodule

// File: rtl/arinc_word_reader.sv
module arinc_word_reader #(
    parameter int WORD_W  = 32,
    parameter int LBL_LSB = 8,
    localparam int BUS_W  = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eow,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              dec_en,
    input  logic [1:0]        dec_bits,
    input  logic              rd_en,
    input  logic              half_sel,
    output logic [BUS_W-1:0]  dbus,
    output logic              dbus_oe,
    output logic              data_ready
);
    logic              accept;
    logic [WORD_W-1:0] held;

    label_filter #(.WORD_W(WORD_W), .LBL_LSB(LBL_LSB)) i_filter (
        .eow(eow), .rx_word(rx_word), .dec_en(dec_en),
        .dec_bits(dec_bits), .accept(accept)
    );

    word_latch #(.WORD_W(WORD_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .load(accept), .d(rx_word), .q(held)
    );

    read_tracker i_track (
        .clk(clk), .rst_n(rst_n), .accept(accept), .rd_en(rd_en),
        .half_sel(half_sel), .pending(data_ready)
    );

    half_mux #(.WORD_W(WORD_W)) i_mux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .half_sel(half_sel),
        .held(held), .dbus(dbus), .dbus_oe(dbus_oe)
    );
endmodule

// File: rtl/arinc_word_reader_chk.sv
module arinc_word_reader_chk #(
    parameter int WORD_W  = 32,
    parameter int LBL_LSB = 8,
    localparam int BUS_W  = WORD_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eow,
    input logic [WORD_W-1:0] rx_word,
    input logic              dec_en,
    input logic [1:0]        dec_bits,
    input logic              rd_en,
    input logic              half_sel,
    input logic [BUS_W-1:0]  dbus,
    input logic              dbus_oe,
    input logic              data_ready
);
    // R2, R4: an accepted word always leaves the flag set
    p_ready_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eow && (!dec_en || rx_word[LBL_LSB +: 2] == dec_bits) |=> data_ready);

    // R5: a rejected word with no read cannot move the flag
    p_reject_keeps_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eow && dec_en && (rx_word[LBL_LSB +: 2] != dec_bits) && !rd_en |=> $stable(data_ready));

    // R3: the flag only rises after an end-of-word pulse
    p_rise_needs_eow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(eow));

    // R7: the flag only falls on a read
    p_fall_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(rd_en));

    // R9: drive enable trails the strobe by one cycle
    p_oe_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> dbus_oe);
    p_oe_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !dbus_oe);

    // R9: bus data holds without a strobe
    p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dbus));
endmodule

bind arinc_word_reader arinc_word_reader_chk #(.WORD_W(WORD_W), .LBL_LSB(LBL_LSB)) i_chk (
    .clk(clk), .rst_n(rst_n), .eow(eow), .rx_word(rx_word), .dec_en(dec_en),
    .dec_bits(dec_bits), .rd_en(rd_en), .half_sel(half_sel), .dbus(dbus),
    .dbus_oe(dbus_oe), .data_ready(data_ready)
);

// File: tb/test_arinc_word_reader.sv
module test_arinc_word_reader;

    typedef struct packed {
        logic        eow;
        logic [31:0] word;
        logic        den;
        logic [1:0]  dbits;
        logic        rd;
        logic        sel;
        logic        x_dr;
        logic        x_oe;
        logic [15:0] x_bus;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] WA = 32'hA5A5_0100; // label bits 01
    localparam logic [31:0] WB = 32'h1234_5E00; // label bits 10
    localparam logic [31:0] WC = 32'hCAFE_0300; // label bits 11
    localparam int NV = 18;

    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd1}, // R1 idle
        '{1'b1, WA,    1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'd4}, // R4 filter off
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0100, 4'd6}, // R6 low half
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0100, 4'd9}, // R9 hold
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0100, 4'd7}, // R7 repeat low
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 16'hA5A5, 4'd7}, // R7 both read
        '{1'b1, WB,    1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5A5, 4'd5}, // R5 reject
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0100, 4'd5}, // R5 latch kept
        '{1'b1, WB,    1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0100, 4'd3}, // R3 match
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1234, 4'd6}, // R6 high half
        '{1'b1, WC,    1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1234, 4'd8}, // R8 overwrite
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0300, 4'd8}, // R8 tracking reset
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 16'hCAFE, 4'd7}, // R7 done
        '{1'b1, WB,    1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0300, 4'd8}, // R8 same cycle
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h5E00, 4'd8}, // R8 new word
        '{1'b1, WA,    1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5E00, 4'd5}, // R5 reject pending
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h1234, 4'd5}, // R5 kept word
        '{1'b0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h5E00, 4'd7}  // R7 idle read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eow = 1'b0;
    logic [31:0] rx_word = '0;
    logic        dec_en = 1'b0;
    logic [1:0]  dec_bits = '0;
    logic        rd_en = 1'b0;
    logic        half_sel = 1'b0;
    logic [15:0] dbus;
    logic        dbus_oe;
    logic        data_ready;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    arinc_word_reader i_arinc_word_reader (
        .clk(clk), .rst_n(rst_n), .eow(eow), .rx_word(rx_word), .dec_en(dec_en),
        .dec_bits(dec_bits), .rd_en(rd_en), .half_sel(half_sel), .dbus(dbus),
        .dbus_oe(dbus_oe), .data_ready(data_ready)
    );

    task automatic check(input int req, input logic x_dr, input logic x_oe,
                         input logic [15:0] x_bus);
        n_vec++;
        if (data_ready !== x_dr || dbus_oe !== x_oe || dbus !== x_bus) begin
            n_bad++;
            $display("FAIL R%0d: dr/oe/bus = %b/%b/%h, expected %b/%b/%h",
                     req, data_ready, dbus_oe, dbus, x_dr, x_oe, x_bus);
        end
    endtask

    task automatic drive(input logic e, input logic [31:0] w, input logic de,
                         input logic [1:0] db, input logic r, input logic s);
        eow = e; rx_word = w; dec_en = de; dec_bits = db; rd_en = r; half_sel = s;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 1'b0, 16'h0000);            // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, 1'b0, 16'h0000);            // R1 after release

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].eow, TBL[i].word, TBL[i].den, TBL[i].dbits,
                  TBL[i].rd, TBL[i].sel);
            @(negedge clk);
            check(int'(TBL[i].req), TBL[i].x_dr, TBL[i].x_oe, TBL[i].x_bus);
        end

        // R2: capture and read straight back
        drive(1'b1, WC, 1'b1, 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        check(2, 1'b1, 1'b0, 16'h5E00);
        drive(1'b0, '0, 1'b0, 2'b00, 1'b1, 1'b1);
        @(negedge clk);
        check(2, 1'b1, 1'b1, 16'hCAFE);

        // R1: reset mid-word clears outputs
        drive(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 1'b0, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: held word cleared by reset
        drive(1'b0, '0, 1'b0, 2'b00, 1'b1, 1'b1);
        @(negedge clk);
        check(1, 1'b0, 1'b1, 16'h0000);
        drive(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule